// File: doc/BRIEF.md
# Microcontroller Reset Sequencer with Illegal-Fetch Trap

This block produces the system reset for a small 8-bit microcontroller core. While the core runs, it watches every opcode fetch on the bus and raises a reset when the fetch address lies outside both executable windows. Two further reset sources feed the same path:

- a low-voltage detector, which acts only when an option bit enables it;
- an external, active-low reset pin.

Every reset, power-on included, starts with a fixed-length pin pulldown. The block then waits for the pin to read high. It fetches the two-byte start vector, one byte per cycle, and hands the assembled program counter to the core with a one-cycle load strobe.

While the sequence runs, `core_init_o` stays high. The surrounding logic uses this level to apply its reset defaults:

- set the interrupt mask and the external-interrupt enable;
- clear the stop and wait latches;
- clear the port direction and pulldown-inhibit bits, leaving port data untouched;
- clear the timer counter, flag and enable;
- load the stack pointer from `sp_init_o` and the timer rate select from `rt_sel_init_o`.

A sticky cause register records which sources started the last reset. Software reads it, and the read clears it.

Top module: `mcu_rst_seq`

## Requirements
- R1: While running, an opcode fetch (`bus_req_i` and `bus_fetch_i` both 1) at an address outside 0x0020..0x00FF and outside 0x0700..0x1FFF starts a reset: `rst_pull_o` is 1 in the cycle after the fetch. A fetch inside either window, including each window's end addresses, has no effect.
- R2: A bus access with `bus_fetch_i`=0 (a data read or write) never starts a reset, whatever its address.
- R3: The pin pulldown `rst_pull_o` stays high for exactly 4 consecutive cycles per reset, and `core_init_o` is high throughout.
- R4: After the pulldown, the sequence stalls, with no vector read, for as long as `rst_pin_i` reads 0.
- R5: The vector is read over two consecutive cycles: first 0x1FFE (high byte), then 0x1FFF (low byte). `vec_data_i` is sampled in the cycle of each read.
- R6: After the low-byte read, `pc_load_o` pulses for one cycle with `pc_o` = {high byte, low byte}. In the next cycle `core_init_o` is 0.
- R7: `lvd_i` starts a reset only while `lv_rst_en_i` is 1.
- R8: `cause_o` holds sticky bits: bit 0 for an illegal fetch, bit 1 for low voltage, bit 2 for the external pin. Every source active in the triggering cycle is recorded, and simultaneous sources start a single sequence. A cycle with `cause_rd_i`=1 clears the bits in the following cycle; a source active in that same cycle is still recorded.
- R9: While running, `rst_pin_i`=0 starts a reset.
- R10: After `rst_ni` is released, the full sequence runs with `cause_o`=0. `sp_init_o` is 0xFF and `rt_sel_init_o` is 2'b11, the slowest rate.
- R11: Reset sources are ignored while a sequence is in progress: they neither restart it nor set cause bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| bus_req_i | input | 1 | Bus access valid |
| bus_fetch_i | input | 1 | Access is an opcode fetch |
| bus_addr_i | input | 16 | Access address |
| lvd_i | input | 1 | Low-voltage detector output |
| lv_rst_en_i | input | 1 | Option bit enabling the low-voltage reset |
| rst_pin_i | input | 1 | Synchronised level of the reset pin (0 = low) |
| rst_pull_o | output | 1 | Drives the pin pulldown |
| core_init_o | output | 1 | Core and peripherals held at reset defaults |
| vec_rd_o | output | 1 | Vector byte read strobe |
| vec_addr_o | output | 16 | Vector byte address |
| vec_data_i | input | 8 | Vector byte returned in the same cycle |
| pc_load_o | output | 1 | Program counter load strobe |
| pc_o | output | 16 | Assembled start address |
| sp_init_o | output | 8 | Stack pointer reset value |
| rt_sel_init_o | output | 2 | Timer rate-select reset value |
| cause_rd_i | input | 1 | Cause register read, which clears it |
| cause_o | output | 3 | Sticky reset-cause bits |

## Verification
The bench builds the block with its defaults: a 16-bit address bus, 8-bit data and a 4-cycle pulldown. These keep each sequence at about eight cycles, so many resets fit in a short run. They also let the bench probe every window edge (0x001F/0x0020, 0x00FF/0x0100, 0x06FF/0x0700, 0x1FFF/0x2000) directly. A behavioural model tracks the phase, the vector bytes and the cause bits on every clock, and varies the pin hold time and the vector contents between sequences.

// File: rtl/mcu_rst_pkg.sv
package mcu_rst_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_PULL, ST_PINW, ST_VHI, ST_VLO, ST_LOAD
  } seq_state_e;

  localparam int CAUSE_W   = 3;
  localparam int CAUSE_ILL = 0;
  localparam int CAUSE_LV  = 1;
  localparam int CAUSE_EXT = 2;
endpackage

// File: rtl/fetch_window_chk.sv
module fetch_window_chk #(
  parameter int AW = 16,
  parameter logic [AW-1:0] PROG_LO = 'h0700,
  parameter logic [AW-1:0] PROG_HI = 'h1FFF,
  parameter logic [AW-1:0] RAM_LO  = 'h0020,
  parameter logic [AW-1:0] RAM_HI  = 'h00FF
) (
  input  logic [AW-1:0] addr_i,
  output logic          legal_o
);
  logic in_prog, in_ram;
  assign in_prog = (addr_i >= PROG_LO) && (addr_i <= PROG_HI);
  assign in_ram  = (addr_i >= RAM_LO)  && (addr_i <= RAM_HI);
  assign legal_o = in_prog || in_ram;
endmodule

// File: rtl/rst_src_merge.sv
module rst_src_merge
  import mcu_rst_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               armed_i,
  input  logic               ill_i,
  input  logic               lv_i,
  input  logic               lv_en_i,
  input  logic               pin_low_i,
  input  logic               rd_i,
  output logic               trig_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [CAUSE_W-1:0] src, cause_q;

  always_comb begin
    src = '0;
    src[CAUSE_ILL] = ill_i;
    src[CAUSE_LV]  = lv_i && lv_en_i;
    src[CAUSE_EXT] = pin_low_i;
    if (!armed_i) src = '0;
  end

  assign trig_o = |src;

  // set wins over read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= (rd_i ? '0 : cause_q) | src;
  end

  assign cause_o = cause_q;

  AST_CAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i && !trig_o |=> cause_o == $past(cause_o)); // R8
  AST_LV_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cause_o[CAUSE_LV]) |-> $past(lv_en_i)); // R7
  AST_ARMED_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> (cause_o & ~$past(cause_o)) == '0); // R11
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import mcu_rst_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int PULL_CYC = 4,
  parameter logic [AW-1:0] VEC_HI_ADDR = 'h1FFE,
  parameter logic [AW-1:0] VEC_LO_ADDR = 'h1FFF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trig_i,
  input  logic            pin_high_i,
  input  logic [DW-1:0]   vec_data_i,
  output logic            run_o,
  output logic            pull_o,
  output logic            init_o,
  output logic            vec_rd_o,
  output logic [AW-1:0]   vec_addr_o,
  output logic            pc_load_o,
  output logic [2*DW-1:0] pc_o
);
  localparam int CNT_W = $clog2(PULL_CYC) + 1;

  seq_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [DW-1:0]     hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_PULL;
      cnt   <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else begin
      unique case (state)
        ST_RUN:  if (trig_i) begin state <= ST_PULL; cnt <= '0; end
        ST_PULL: begin
          if (cnt == CNT_W'(PULL_CYC - 1)) state <= ST_PINW;
          else                             cnt   <= cnt + 1'b1;
        end
        ST_PINW: if (pin_high_i) state <= ST_VHI;
        ST_VHI:  begin hi_q <= vec_data_i; state <= ST_VLO; end
        ST_VLO:  begin lo_q <= vec_data_i; state <= ST_LOAD; end
        ST_LOAD: state <= ST_RUN;
        default: state <= ST_PULL;
      endcase
    end
  end

  assign run_o      = (state == ST_RUN);
  assign pull_o     = (state == ST_PULL);
  assign init_o     = (state != ST_RUN);
  assign vec_rd_o   = (state == ST_VHI) || (state == ST_VLO);
  assign vec_addr_o = (state == ST_VLO) ? VEC_LO_ADDR : VEC_HI_ADDR;
  assign pc_load_o  = (state == ST_LOAD);
  assign pc_o       = {hi_q, lo_q};

  // independent run-length of the pulldown for the length check
  logic [CNT_W:0] pull_len;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pull_len <= '0;
    else if (pull_o) pull_len <= pull_len + 1'b1;
    else             pull_len <= '0;
  end

  AST_PULL_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pull_o) |-> pull_len == (CNT_W+1)'(PULL_CYC)); // R3
  AST_PIN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_PINW && !pin_high_i |=> !vec_rd_o); // R4
  AST_VEC_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd_o && vec_addr_o == VEC_LO_ADDR |-> $past(vec_rd_o) && $past(vec_addr_o) == VEC_HI_ADDR); // R5
  AST_LOAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !pc_load_o && !init_o); // R6
endmodule

// File: rtl/mcu_rst_seq.sv
module mcu_rst_seq
  import mcu_rst_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int PULL_CYC = 4,
  parameter int RT_W     = 2,
  parameter logic [AW-1:0] PROG_LO = 'h0700,
  parameter logic [AW-1:0] PROG_HI = 'h1FFF,
  parameter logic [AW-1:0] RAM_LO  = 'h0020,
  parameter logic [AW-1:0] RAM_HI  = 'h00FF,
  parameter logic [AW-1:0] VEC_HI_ADDR = 'h1FFE,
  parameter logic [AW-1:0] VEC_LO_ADDR = 'h1FFF,
  parameter logic [DW-1:0] SP_INIT = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_req_i,
  input  logic               bus_fetch_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic               lvd_i,
  input  logic               lv_rst_en_i,
  input  logic               rst_pin_i,
  output logic               rst_pull_o,
  output logic               core_init_o,
  output logic               vec_rd_o,
  output logic [AW-1:0]      vec_addr_o,
  input  logic [DW-1:0]      vec_data_i,
  output logic               pc_load_o,
  output logic [2*DW-1:0]    pc_o,
  output logic [DW-1:0]      sp_init_o,
  output logic [RT_W-1:0]    rt_sel_init_o,
  input  logic               cause_rd_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic legal, ill_fetch, run, trig;

  fetch_window_chk #(
    .AW(AW), .PROG_LO(PROG_LO), .PROG_HI(PROG_HI), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI)
  ) u_win (
    .addr_i (bus_addr_i),
    .legal_o(legal)
  );

  assign ill_fetch = bus_req_i && bus_fetch_i && !legal;

  rst_src_merge u_merge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .armed_i  (run),
    .ill_i    (ill_fetch),
    .lv_i     (lvd_i),
    .lv_en_i  (lv_rst_en_i),
    .pin_low_i(!rst_pin_i),
    .rd_i     (cause_rd_i),
    .trig_o   (trig),
    .cause_o  (cause_o)
  );

  rst_seq_fsm #(
    .AW(AW), .DW(DW), .PULL_CYC(PULL_CYC),
    .VEC_HI_ADDR(VEC_HI_ADDR), .VEC_LO_ADDR(VEC_LO_ADDR)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig),
    .pin_high_i(rst_pin_i),
    .vec_data_i(vec_data_i),
    .run_o     (run),
    .pull_o    (rst_pull_o),
    .init_o    (core_init_o),
    .vec_rd_o  (vec_rd_o),
    .vec_addr_o(vec_addr_o),
    .pc_load_o (pc_load_o),
    .pc_o      (pc_o)
  );

  assign sp_init_o     = SP_INIT;
  assign rt_sel_init_o = '1; // slowest periodic and watchdog rate

  AST_ILL_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_init_o && bus_req_i && bus_fetch_i && !legal |=> rst_pull_o); // R1
  AST_PIN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_init_o && !rst_pin_i |=> rst_pull_o && cause_o[CAUSE_EXT]); // R9
endmodule

// File: tb/mcu_rst_seq_bench.sv
module mcu_rst_seq_bench;
  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic        req = 0, fetch = 0, lvd = 0, lven = 0, ext_low = 0, crd = 0;
  logic [15:0] addr = 0;
  logic [7:0]  rv_hi = 8'h12, rv_lo = 8'h34;
  logic        pull, init, vrd, pcl;
  logic [15:0] vaddr, pc;
  logic [7:0]  vdata, sp;
  logic [1:0]  rts;
  logic [2:0]  cause;
  logic        pin;

  assign pin   = !(ext_low || pull);
  assign vdata = (vaddr == 16'h1FFE) ? rv_hi : (vaddr == 16'h1FFF) ? rv_lo : 8'h00;

  mcu_rst_seq u_mcu_rst_seq (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_fetch_i(fetch), .bus_addr_i(addr),
    .lvd_i(lvd), .lv_rst_en_i(lven), .rst_pin_i(pin), .rst_pull_o(pull),
    .core_init_o(init), .vec_rd_o(vrd), .vec_addr_o(vaddr), .vec_data_i(vdata),
    .pc_load_o(pcl), .pc_o(pc), .sp_init_o(sp), .rt_sel_init_o(rts),
    .cause_rd_i(crd), .cause_o(cause)
  );

  int vectors = 0, miscompares = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: 0 run,1 pull,2 pin wait,3 hi,4 lo,5 load
  int         m_ph, m_cnt;
  logic [7:0] m_hi, m_lo;
  logic [2:0] m_cause, m_src;

  function automatic bit legal(input logic [15:0] a);
    return (a >= 16'h0020 && a <= 16'h00FF) || (a >= 16'h0700 && a <= 16'h1FFF);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 1; m_cnt <= 0; m_hi <= 0; m_lo <= 0; m_cause <= 0;
    end else begin
      m_src = 3'b000;
      if (m_ph == 0) begin
        if (req && fetch && !legal(addr)) m_src[0] = 1'b1;
        if (lvd && lven)                  m_src[1] = 1'b1;
        if (ext_low)                      m_src[2] = 1'b1;
      end
      m_cause <= (crd ? 3'b000 : m_cause) | m_src;
      case (m_ph)
        0: if (m_src != 0) begin m_ph <= 1; m_cnt <= 0; end
        1: if (m_cnt == 3) m_ph <= 2; else m_cnt <= m_cnt + 1;
        2: if (!ext_low) m_ph <= 3;
        3: begin m_hi <= rv_hi; m_ph <= 4; end
        4: begin m_lo <= rv_lo; m_ph <= 5; end
        default: m_ph <= 0;
      endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(pull == (m_ph == 1), "R3 pulldown", pull, m_ph == 1);
    chk(init == (m_ph != 0), "R10 core_init", init, m_ph != 0);
    chk(vrd == (m_ph == 3 || m_ph == 4), "R5 vec_rd", vrd, m_ph == 3 || m_ph == 4);
    if (m_ph == 3 || m_ph == 4)
      chk(vaddr == ((m_ph == 3) ? 16'h1FFE : 16'h1FFF), "R5 vec_addr", vaddr,
          (m_ph == 3) ? 16'h1FFE : 16'h1FFF);
    chk(pcl == (m_ph == 5), "R6 pc_load", pcl, m_ph == 5);
    if (m_ph == 5) chk(pc == {m_hi, m_lo}, "R6 pc", pc, {m_hi, m_lo});
    chk(cause == m_cause, "R8 cause", cause, m_cause);
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      miscompares++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wait_run();
    for (int n = 0; n < 200 && init; n++) @(negedge clk);
  endtask

  task automatic clear_cause();
    crd = 1; @(negedge clk); crd = 0;
    chk(cause == 3'b000, "R8 read clears", cause, 0);
  endtask

  // one-cycle stimulus, then check for the pulldown in the next cycle
  task automatic hit(input logic r, input logic f, input logic [15:0] a, input logic l,
                     input logic le, input logic e, input bit exp_rst, input string tag);
    req = r; fetch = f; addr = a; lvd = l; lven = le; ext_low = e;
    @(negedge clk);
    req = 0; fetch = 0; lvd = 0; ext_low = 0;
    chk(pull == exp_rst, tag, pull, exp_rst);
    wait_run();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pull && init && cause == 0, "R10 power-on sequence", {pull, init, cause}, 5'b11000);
    chk(sp == 8'hFF && rts == 2'b11, "R10 defaults", {sp, rts}, 10'h3FF);
    wait_run();
    chk(pc == 16'h1234, "R6 power-on pc", pc, 16'h1234);

    // R1 window edges
    hit(1, 1, 16'h0020, 0, 0, 0, 0, "R1 legal 0020");
    hit(1, 1, 16'h00FF, 0, 0, 0, 0, "R1 legal 00FF");
    hit(1, 1, 16'h0700, 0, 0, 0, 0, "R1 legal 0700");
    hit(1, 1, 16'h1FFF, 0, 0, 0, 0, "R1 legal 1FFF");
    rv_hi = 8'hA5; rv_lo = 8'h0F;
    hit(1, 1, 16'h001F, 0, 0, 0, 1, "R1 illegal 001F");
    chk(pc == 16'hA50F, "R6 pc after trap", pc, 16'hA50F);
    chk(cause == 3'b001, "R8 ill cause", cause, 1);
    clear_cause();
    hit(1, 1, 16'h0100, 0, 0, 0, 1, "R1 illegal 0100");
    hit(1, 1, 16'h06FF, 0, 0, 0, 1, "R1 illegal 06FF");
    hit(1, 1, 16'h2000, 0, 0, 0, 1, "R1 illegal 2000");
    clear_cause();

    // R2 data accesses
    hit(1, 0, 16'h2000, 0, 0, 0, 0, "R2 data access 2000");
    hit(1, 0, 16'h0000, 0, 0, 0, 0, "R2 data access 0000");
    hit(0, 1, 16'h0000, 0, 0, 0, 0, "R2 no request");
    chk(cause == 3'b000, "R2 no cause", cause, 0);

    // R7 low voltage gating
    hit(0, 0, 16'h0000, 1, 0, 0, 0, "R7 lv disabled");
    chk(cause == 3'b000, "R7 no cause", cause, 0);
    hit(0, 0, 16'h0000, 1, 1, 0, 1, "R7 lv enabled");
    chk(cause == 3'b010, "R7 lv cause", cause, 2);
    clear_cause();

    // R9 external pin
    rv_hi = 8'h07; rv_lo = 8'hC3;
    hit(0, 0, 16'h0000, 0, 0, 1, 1, "R9 pin low");
    chk(cause == 3'b100 && pc == 16'h07C3, "R9 ext cause/pc", {cause, pc}, {3'b100, 16'h07C3});
    clear_cause();

    // R4 pin held low past the pulldown
    ext_low = 1;
    repeat (12) @(negedge clk);
    chk(init && !vrd && !pull, "R4 stalled on pin low", {init, vrd, pull}, 3'b100);
    ext_low = 0;
    wait_run();
    chk(!init, "R4 released", init, 0);
    clear_cause();

    // R8 simultaneous sources, single sequence
    hit(1, 1, 16'h3000, 1, 1, 1, 1, "R8 merged trigger");
    chk(cause == 3'b111, "R8 all causes", cause, 7);

    // R8 read and new source in the same cycle: the new source is kept
    crd = 1; req = 1; fetch = 1; addr = 16'hF000;
    @(negedge clk);
    crd = 0; req = 0; fetch = 0;
    chk(cause == 3'b001, "R8 set wins over read", cause, 1);
    wait_run();
    clear_cause();

    // R11 sources during a sequence are ignored
    req = 1; fetch = 1; addr = 16'h4000;
    @(negedge clk);
    req = 1; fetch = 1; addr = 16'h5000; lvd = 1; lven = 1;
    @(negedge clk);
    req = 0; fetch = 0; lvd = 0;
    wait_run();
    chk(cause == 3'b001, "R11 ignored in sequence", cause, 1);
    repeat (3) @(negedge clk);
    chk(!init, "R11 no restart", init, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule